// File: doc/BRIEF.md
# Checkpointed Return Address Stack

This block predicts the targets of subroutine returns at the front of an instruction fetch pipeline. When fetch predicts a call, it presents the address of the instruction after the call and the block pushes it. When fetch predicts a return, the block shows the entry on top of the stack as the predicted target and pops it on that clock edge. The stack holds a fixed number of entries. It wraps around when it is full, and it refuses to go below empty.

Calls and returns are acted on before the branches that lead to them are resolved. For this reason, fetch asks for a checkpoint at every predicted branch and gets back a small tag. If that branch later turns out to be mispredicted, fetch sends the tag back with a restore strobe. A checkpoint holds three things: the top-of-stack pointer, the occupancy count, and the value of the entry on top. A wrong-path pop followed by a push destroys that entry, and the restore writes it back.

Top module: `checkpointed_ras`

## Requirements
- R1: After reset the stack is empty, `pred_valid_o` is 0 and `ckpt_tag_o` is 0.
- R2: A cycle with `call_i`=1, `ret_i`=0 and no restore pushes `ret_addr_i`. From the next cycle, `pred_valid_o`=1 and `pred_target_o` equals that address.
- R3: `pred_target_o` always shows the top entry, and `pred_valid_o` is 1 exactly when the stack holds at least one entry. A cycle with `ret_i`=1, `call_i`=0 and no restore on a non-empty stack pops one entry, and the entry below becomes visible on the next cycle.
- R4: The stack holds DEPTH entries. A push onto a full stack overwrites the oldest entry and the count stays at DEPTH. After more than DEPTH pushes, pops return the newest DEPTH addresses in reverse order and then the stack reads empty.
- R5: A return on an empty stack has no effect: `pred_valid_o` stays 0, and the next push behaves as a push onto an empty stack.
- R6: If `call_i` and `ret_i` are both 1 on a non-empty stack, the top entry is replaced by `ret_addr_i` and the count does not change. On an empty stack the pair acts as a plain push.
- R7: `ckpt_tag_o` names the slot that a save in the current cycle fills. Slots are given out in circular order 0,1,2,3,0,…, and the tag advances by one after each save that is not cancelled by a restore.
- R8: A restore with `restore_tag_i` puts back the saved pointer, count and top entry. The restored prediction is visible on the next cycle, including a top entry that a wrong-path pop followed by a push had overwritten.
- R9: A restore wins over a call, a return and a save in the same cycle. Those are ignored, and `ckpt_tag_o` does not advance.
- R10: A save captures the stack state from before any call or return in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| call_i | input | 1 | Predicted call: push `ret_addr_i` |
| ret_i | input | 1 | Predicted return: pop the top entry |
| ret_addr_i | input | AW | Address of the instruction after the call |
| ckpt_save_i | input | 1 | Save a checkpoint of the current stack state |
| ckpt_tag_o | output | TAG_W | Tag of the slot that a save in this cycle fills |
| restore_i | input | 1 | Restore the checkpoint named by `restore_tag_i` |
| restore_tag_i | input | TAG_W | Tag of the checkpoint to restore |
| pred_target_o | output | AW | Predicted return target (top entry) |
| pred_valid_o | output | 1 | Stack is non-empty, so the target is meaningful |

## Verification
The bench goes after four corner cases:
- Pushing past full. A design with a wrong wrap or count would return stale addresses, or would show the stack as empty too early or too late.
- Popping an empty stack. A design that moves the pointer here would misplace the next push.
- A pop then a push on the wrong path, followed by a restore. A design that saves only the pointer would predict the wrong-path address instead of the original top.
- Same-cycle collisions: restore with call or save, save with return, and call with return. A design with the wrong priority would leave a push in place, advance the tag, or checkpoint the post-pop state.

Random mixes are compared every cycle against a reference model of the requirements.

// File: rtl/ras_pkg.sv
package ras_pkg;
  // Source of the single write into the entry array in a cycle
  typedef enum logic [1:0] {
    WR_NONE    = 2'd0,
    WR_PUSH    = 2'd1,
    WR_REPLACE = 2'd2,
    WR_RESTORE = 2'd3
  } wr_src_e;
endpackage

// File: rtl/ras_store.sv
module ras_store #(
  parameter int DEPTH = 8,
  parameter int AW    = 32,
  parameter int PTR_W = 3
) (
  input  logic             clk,
  input  logic             we_i,
  input  logic [PTR_W-1:0] widx_i,
  input  logic [AW-1:0]    wdata_i,
  input  logic [PTR_W-1:0] ridx_i,
  output logic [AW-1:0]    rdata_o
);
  logic [AW-1:0] entry_q [DEPTH];

  // Data array: no reset, one clock enable per entry
  for (genvar g = 0; g < DEPTH; g++) begin : g_entry
    logic en;
    assign en = we_i && (widx_i == PTR_W'(g));
    always_ff @(posedge clk) begin
      if (en) entry_q[g] <= wdata_i;
    end
  end

  assign rdata_o = entry_q[ridx_i];
endmodule

// File: rtl/ras_ctrl.sv
module ras_ctrl
  import ras_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int AW    = 32,
  parameter int PTR_W = 3,
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             call_i,
  input  logic             ret_i,
  input  logic [AW-1:0]    ret_addr_i,
  input  logic             restore_i,
  input  logic [PTR_W-1:0] rs_tos_i,
  input  logic [CNT_W-1:0] rs_cnt_i,
  input  logic [AW-1:0]    rs_top_i,
  output logic [PTR_W-1:0] tos_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic             we_o,
  output logic [PTR_W-1:0] widx_o,
  output logic [AW-1:0]    wdata_o
);
  localparam logic [PTR_W-1:0] LAST_IDX = PTR_W'(DEPTH - 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

  logic [PTR_W-1:0] tos_q, tos_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             upd_en;
  wr_src_e          src;
  logic             not_empty;

  assign not_empty = (cnt_q != '0);

  always_comb begin
    tos_d = tos_q;
    cnt_d = cnt_q;
    src   = WR_NONE;
    if (restore_i) begin
      tos_d = rs_tos_i;
      cnt_d = rs_cnt_i;
      src   = WR_RESTORE;
    end else if (call_i && ret_i && not_empty) begin
      src = WR_REPLACE;
    end else if (call_i) begin
      tos_d = (tos_q == LAST_IDX) ? '0 : tos_q + 1'b1;
      cnt_d = (cnt_q == FULL_CNT) ? cnt_q : cnt_q + 1'b1;
      src   = WR_PUSH;
    end else if (ret_i && not_empty) begin
      tos_d = (tos_q == '0) ? LAST_IDX : tos_q - 1'b1;
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_comb begin
    we_o    = (src != WR_NONE);
    wdata_o = (src == WR_RESTORE) ? rs_top_i : ret_addr_i;
    unique case (src)
      WR_PUSH:    widx_o = tos_d;
      WR_RESTORE: widx_o = rs_tos_i;
      default:    widx_o = tos_q;
    endcase
  end

  assign upd_en = restore_i || call_i || ret_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tos_q <= '0;
      cnt_q <= '0;
    end else if (upd_en) begin
      tos_q <= tos_d;
      cnt_q <= cnt_d;
    end
  end

  assign tos_o = tos_q;
  assign cnt_o = cnt_q;
endmodule

// File: rtl/ras_ckpt.sv
module ras_ckpt #(
  parameter int SLOTS = 4,
  parameter int AW    = 32,
  parameter int PTR_W = 3,
  parameter int CNT_W = 4,
  parameter int TAG_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             save_i,
  input  logic             restore_i,
  input  logic [TAG_W-1:0] rtag_i,
  input  logic [PTR_W-1:0] cur_tos_i,
  input  logic [CNT_W-1:0] cur_cnt_i,
  input  logic [AW-1:0]    cur_top_i,
  output logic [TAG_W-1:0] tag_o,
  output logic [PTR_W-1:0] rs_tos_o,
  output logic [CNT_W-1:0] rs_cnt_o,
  output logic [AW-1:0]    rs_top_o
);
  localparam logic [TAG_W-1:0] LAST_TAG = TAG_W'(SLOTS - 1);

  logic [TAG_W-1:0] alloc_q, alloc_d;
  logic             take;
  logic [PTR_W-1:0] s_tos_q [SLOTS];
  logic [CNT_W-1:0] s_cnt_q [SLOTS];
  logic [AW-1:0]    s_top_q [SLOTS];

  assign take    = save_i && !restore_i;
  assign alloc_d = (alloc_q == LAST_TAG) ? '0 : alloc_q + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    alloc_q <= '0;
    else if (take) alloc_q <= alloc_d;
  end

  for (genvar g = 0; g < SLOTS; g++) begin : g_slot
    logic en;
    assign en = take && (alloc_q == TAG_W'(g));
    always_ff @(posedge clk) begin
      if (en) begin
        s_tos_q[g] <= cur_tos_i;
        s_cnt_q[g] <= cur_cnt_i;
        s_top_q[g] <= cur_top_i;
      end
    end
  end

  assign tag_o    = alloc_q;
  assign rs_tos_o = s_tos_q[rtag_i];
  assign rs_cnt_o = s_cnt_q[rtag_i];
  assign rs_top_o = s_top_q[rtag_i];
endmodule

// File: rtl/checkpointed_ras.sv
module checkpointed_ras #(
  parameter int DEPTH      = 8,
  parameter int AW         = 32,
  parameter int CKPT_SLOTS = 4,
  parameter int TAG_W      = $clog2(CKPT_SLOTS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             call_i,
  input  logic             ret_i,
  input  logic [AW-1:0]    ret_addr_i,
  input  logic             ckpt_save_i,
  output logic [TAG_W-1:0] ckpt_tag_o,
  input  logic             restore_i,
  input  logic [TAG_W-1:0] restore_tag_i,
  output logic [AW-1:0]    pred_target_o,
  output logic             pred_valid_o
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic             rst_meta_q, rst_sync_n;
  logic [PTR_W-1:0] tos, rs_tos, widx;
  logic [CNT_W-1:0] cnt_q, rs_cnt;
  logic [AW-1:0]    top, rs_top, wdata;
  logic             we;

  // Reset asserts at once, releases on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  ras_ctrl #(.DEPTH(DEPTH), .AW(AW), .PTR_W(PTR_W), .CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rst_n(rst_sync_n),
    .call_i(call_i), .ret_i(ret_i), .ret_addr_i(ret_addr_i),
    .restore_i(restore_i), .rs_tos_i(rs_tos), .rs_cnt_i(rs_cnt), .rs_top_i(rs_top),
    .tos_o(tos), .cnt_o(cnt_q), .we_o(we), .widx_o(widx), .wdata_o(wdata)
  );

  ras_store #(.DEPTH(DEPTH), .AW(AW), .PTR_W(PTR_W)) u_store (
    .clk(clk), .we_i(we), .widx_i(widx), .wdata_i(wdata),
    .ridx_i(tos), .rdata_o(top)
  );

  ras_ckpt #(.SLOTS(CKPT_SLOTS), .AW(AW), .PTR_W(PTR_W), .CNT_W(CNT_W), .TAG_W(TAG_W)) u_ckpt (
    .clk(clk), .rst_n(rst_sync_n),
    .save_i(ckpt_save_i), .restore_i(restore_i), .rtag_i(restore_tag_i),
    .cur_tos_i(tos), .cur_cnt_i(cnt_q), .cur_top_i(top),
    .tag_o(ckpt_tag_o), .rs_tos_o(rs_tos), .rs_cnt_o(rs_cnt), .rs_top_o(rs_top)
  );

  assign pred_target_o = top;
  assign pred_valid_o  = (cnt_q != '0);
endmodule

// File: rtl/ras_checker.sv
module ras_checker #(
  parameter int DEPTH = 8,
  parameter int AW    = 32,
  parameter int TAG_W = 2,
  parameter int CNT_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             call_i,
  input logic             ret_i,
  input logic [AW-1:0]    ret_addr_i,
  input logic             ckpt_save_i,
  input logic [TAG_W-1:0] ckpt_tag_o,
  input logic             restore_i,
  input logic [AW-1:0]    pred_target_o,
  input logic             pred_valid_o,
  input logic [CNT_W-1:0] depth_q
);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

  p_push_top_r2: assert property (@(posedge clk) disable iff (!rst_n)
    call_i && !ret_i && !restore_i |=> pred_valid_o && (pred_target_o == $past(ret_addr_i)));

  p_pop_count_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ret_i && !call_i && !restore_i && (depth_q != '0) |=> depth_q == $past(depth_q) - 1'b1);

  p_no_overflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
    depth_q <= FULL_CNT);

  p_full_stays_r4: assert property (@(posedge clk) disable iff (!rst_n)
    call_i && !ret_i && !restore_i && (depth_q == FULL_CNT) |=> depth_q == FULL_CNT);

  p_underflow_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ret_i && !call_i && !restore_i && !pred_valid_o |=> !pred_valid_o);

  p_replace_top_r6: assert property (@(posedge clk) disable iff (!rst_n)
    call_i && ret_i && !restore_i && (depth_q != '0)
      |=> (depth_q == $past(depth_q)) && (pred_target_o == $past(ret_addr_i)));

  p_tag_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ckpt_save_i && !restore_i |=> ckpt_tag_o == TAG_W'($past(ckpt_tag_o) + 1'b1));

  p_tag_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    restore_i || !ckpt_save_i |=> $stable(ckpt_tag_o));
endmodule

bind checkpointed_ras ras_checker #(.DEPTH(DEPTH), .AW(AW), .TAG_W(TAG_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_sync_n),
  .call_i(call_i), .ret_i(ret_i), .ret_addr_i(ret_addr_i),
  .ckpt_save_i(ckpt_save_i), .ckpt_tag_o(ckpt_tag_o), .restore_i(restore_i),
  .pred_target_o(pred_target_o), .pred_valid_o(pred_valid_o), .depth_q(cnt_q)
);

// File: tb/checkpointed_ras_test.sv
module checkpointed_ras_test;
  localparam int DEPTH = 8;
  localparam int AW    = 32;
  localparam int SLOTS = 4;
  localparam int TAG_W = 2;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             call_i, ret_i, ckpt_save_i, restore_i;
  logic [AW-1:0]    ret_addr_i;
  logic [TAG_W-1:0] restore_tag_i, ckpt_tag_o;
  logic [AW-1:0]    pred_target_o;
  logic             pred_valid_o;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  // reference model state
  logic [AW-1:0] m_stk [DEPTH];
  int m_tos, m_cnt, m_alloc;
  int ck_tos [SLOTS];
  int ck_cnt [SLOTS];
  logic [AW-1:0] ck_top [SLOTS];
  bit ck_used [SLOTS];

  always #2 clk = ~clk;

  checkpointed_ras #(.DEPTH(DEPTH), .AW(AW), .CKPT_SLOTS(SLOTS)) uut (
    .clk(clk), .rst_n(rst_n), .call_i(call_i), .ret_i(ret_i), .ret_addr_i(ret_addr_i),
    .ckpt_save_i(ckpt_save_i), .ckpt_tag_o(ckpt_tag_o), .restore_i(restore_i),
    .restore_tag_i(restore_tag_i), .pred_target_o(pred_target_o), .pred_valid_o(pred_valid_o)
  );

  function automatic void model_step(bit c, bit r, logic [AW-1:0] a, bit s, bit rs, int rt);
    if (s && !rs) begin  // R10: capture state before this cycle's call/return
      ck_tos[m_alloc] = m_tos;
      ck_cnt[m_alloc] = m_cnt;
      ck_top[m_alloc] = m_stk[m_tos];
      ck_used[m_alloc] = 1'b1;
      m_alloc = (m_alloc + 1) % SLOTS;
    end
    if (rs) begin         // R8, R9
      m_tos = ck_tos[rt];
      m_cnt = ck_cnt[rt];
      m_stk[m_tos] = ck_top[rt];
    end else if (c && r && m_cnt != 0) begin  // R6
      m_stk[m_tos] = a;
    end else if (c) begin // R2, R4
      m_tos = (m_tos + 1) % DEPTH;
      m_stk[m_tos] = a;
      if (m_cnt < DEPTH) m_cnt++;
    end else if (r && m_cnt != 0) begin  // R3; R5 when empty
      m_tos = (m_tos + DEPTH - 1) % DEPTH;
      m_cnt--;
    end
  endfunction

  task automatic check(string req);
    bit ev;
    ev = (m_cnt != 0);
    n_chk++;
    if (pred_valid_o !== ev) begin
      n_bad++;
      $display("FAIL %s valid: actual %0b expected %0b", req, pred_valid_o, ev);
    end
    if (ev) begin
      n_chk++;
      if (pred_target_o !== m_stk[m_tos]) begin
        n_bad++;
        $display("FAIL %s target: actual %h expected %h", req, pred_target_o, m_stk[m_tos]);
      end
    end
    n_chk++;
    if (ckpt_tag_o !== TAG_W'(m_alloc)) begin
      n_bad++;
      $display("FAIL %s tag: actual %0d expected %0d", req, ckpt_tag_o, m_alloc);
    end
  endtask

  task automatic step(bit c, bit r, logic [AW-1:0] a, bit s, bit rs, int rt, string req);
    call_i = c; ret_i = r; ret_addr_i = a; ckpt_save_i = s;
    restore_i = rs; restore_tag_i = TAG_W'(rt);
    @(posedge clk);
    model_step(c, r, a, s, rs, rt);
    #1;
    check(req);
    @(negedge clk);
    call_i = 0; ret_i = 0; ckpt_save_i = 0; restore_i = 0;
  endtask

  task automatic expect_target(logic [AW-1:0] exp, string req);
    n_chk++;
    if (pred_valid_o !== 1'b1 || pred_target_o !== exp) begin
      n_bad++;
      $display("FAIL %s directed: actual %h/%0b expected %h/1", req, pred_target_o, pred_valid_o, exp);
    end
  endtask

  initial begin
    #(4 * 100000);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    rst_n = 0; call_i = 0; ret_i = 0; ckpt_save_i = 0; restore_i = 0;
    ret_addr_i = '0; restore_tag_i = '0;
    for (int i = 0; i < DEPTH; i++) m_stk[i] = '0;
    for (int i = 0; i < SLOTS; i++) ck_used[i] = 0;
    m_tos = 0; m_cnt = 0; m_alloc = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
    check("R1");

    // R2 / R3 push then pop
    step(1, 0, 32'hA000, 0, 0, 0, "R2");
    step(1, 0, 32'hB000, 0, 0, 0, "R2");
    expect_target(32'hB000, "R2");
    step(0, 1, 0, 0, 0, 0, "R3");
    expect_target(32'hA000, "R3");
    step(0, 1, 0, 0, 0, 0, "R3");
    // R5 underflow
    step(0, 1, 0, 0, 0, 0, "R5");
    step(0, 1, 0, 0, 0, 0, "R5");
    step(1, 0, 32'hC000, 0, 0, 0, "R5");
    step(0, 1, 0, 0, 0, 0, "R5");

    // R4 overflow
    for (int i = 0; i < DEPTH + 2; i++) step(1, 0, 32'h100 + i, 0, 0, 0, "R4");
    for (int i = 0; i < DEPTH + 1; i++) step(0, 1, 0, 0, 0, 0, "R4");

    // R6 call and return together
    step(1, 1, 32'hD000, 0, 0, 0, "R6");
    step(1, 1, 32'hD100, 0, 0, 0, "R6");
    expect_target(32'hD100, "R6");
    step(0, 1, 0, 0, 0, 0, "R6");

    // R7 tag wrap: 5 saves
    for (int i = 0; i < 5; i++) step(0, 0, 0, 1, 0, 0, "R7");

    // R8 / R10 wrong-path pop then push, repaired by restore
    step(1, 0, 32'hE001, 0, 0, 0, "R8");
    step(1, 0, 32'hE002, 0, 0, 0, "R8");
    begin
      int t;
      t = m_alloc;
      step(0, 1, 0, 1, 0, 0, "R10");
      step(1, 0, 32'hBAD0, 0, 0, 0, "R8");
      step(0, 0, 0, 0, 1, t, "R8");
      expect_target(32'hE002, "R8");
      step(0, 1, 0, 0, 0, 0, "R8");
      expect_target(32'hE001, "R8");
      // R9 restore beats call and save
      step(1, 0, 32'hBAD1, 1, 1, t, "R9");
      expect_target(32'hE002, "R9");
    end

    // random mix
    for (int i = 0; i < 4000; i++) begin
      bit c, r, s, rs;
      int rt;
      c  = ($urandom % 10) < 3;
      r  = ($urandom % 10) < 3;
      s  = ($urandom % 10) < 2;
      rs = ($urandom % 10) < 1;
      rt = $urandom % SLOTS;
      if (!ck_used[rt]) rs = 0;
      step(c, r, $urandom, s, rs, rt, "R3 random");
    end

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule